// File: doc/BRIEF.md
# Target-First Chess Move Generator

This block produces the pseudo-legal moves of one 8x8 chess position, one move per request, in a fixed priority order. It holds a registered copy of the board, the side to move and a killer move. Around that state it keeps two always-active combinational arrays of 64 square cells. In the victim array each square decides, by looking outward from itself, whether some piece of the side to move can land on it. A comparator tree over those 64 flags picks the most attractive destination that has not been used up yet.

In the aggressor array each square decides whether its own piece can reach the chosen destination along a clear path. That search behaves like a super-piece signal sent back from the target. A second comparator tree picks the cheapest such attacker. The pair (origin, target) is presented on the outputs. A `next` strobe consumes it. When the last origin of a target has been consumed, the target is marked as examined. A `load` strobe replaces the position and forgets all history.

Checking whether the own king is left in check, castling, en passant and the choice of promotion piece are not part of this block. A pawn reaching the last rank appears as an ordinary pawn move.

Top module: `chess_mvgen`

## Requirements
- R1: After reset the board is empty, `done` is 1 and `mv_valid` is 0.
- R2: Squares are numbered rank*8+file, with index 0 on White's first rank. Each square carries 4 bits: bit 3 is the colour (0 white, 1 black) and bits 2:0 are the kind (0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king). Every emitted move starts on a piece of the side to move and follows that piece's pattern. Bishops, rooks and queens stop at the first occupied square. No move ends on an own piece.
- R3: Every pseudo-legal move of the loaded position is emitted exactly once before `done` rises.
- R4: Targets are ranked by score. A capture of kind k scores 2+k. A move to an empty square scores 0. Higher-scoring targets come first, so every capture precedes every quiet move.
- R5: If the killer (from, to) pair is a pseudo-legal move to an empty square, its target scores 1. It therefore comes directly after all captures.
- R6: All origins of one target are emitted back to back. The order is ascending attacker kind, and attackers of equal kind come in ascending square index.
- R7: Targets of equal score are emitted in ascending square index.
- R8: `done` is 1 exactly when no unexamined target remains. `mv_valid` is then 0, and `next` has no effect.
- R9: `load` clears the history of examined targets and emitted origins. Reloading a position restarts its move sequence from the first move.
- R10: A White pawn moves by +8 and a Black pawn by -8. A pawn pushes one step onto an empty square. It pushes two steps from its home rank (rank 1 for White, rank 6 for Black) when both squares are empty. It captures one file aside, one step forward, and only onto an enemy piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture a new position, side and killer |
| board_in | input | 256 | 64 squares of 4 bits, square s at bits 4s+3:4s |
| side_in | input | 1 | Side to move, 0 white, 1 black |
| killer_from | input | 6 | Killer move origin square |
| killer_to | input | 6 | Killer move target square |
| next | input | 1 | Consume the presented move |
| mv_valid | output | 1 | A move is presented |
| mv_from | output | 6 | Origin square of the presented move |
| mv_to | output | 6 | Target square of the presented move |
| done | output | 1 | No move remains |

## Verification
Every output is combinational from registered state. A result is therefore due in the first cycle after the clock edge that captured `load` or `next`, and no further pipeline delay applies. The bench drives inputs on the falling edge and reads outputs on the following falling edge, one rising edge later, before it changes anything. Along each full move sequence, every move is checked against a piece-centric move list and against the score and attacker ordering rules. The bench also checks that `next` after exhaustion leaves the block done, and that a reload reproduces the first move.

// File: rtl/mvg_pkg.sv
package mvg_pkg;

    localparam int BOARD_DIM = 8;
    localparam int N_SQ      = BOARD_DIM * BOARD_DIM;
    localparam int SQ_W      = $clog2(N_SQ);
    localparam int CELL_W    = 4;
    localparam int SCORE_W   = 4;
    localparam int RANK_W    = 3;

    typedef enum logic [2:0] {
        PK_NONE   = 3'd0,
        PK_PAWN   = 3'd1,
        PK_KNIGHT = 3'd2,
        PK_BISHOP = 3'd3,
        PK_ROOK   = 3'd4,
        PK_QUEEN  = 3'd5,
        PK_KING   = 3'd6
    } kind_e;

    typedef struct packed {
        logic  black;
        kind_e kind;
    } cell_t;

    typedef cell_t [N_SQ-1:0] board_t;

    function automatic logic is_own(cell_t c, logic side);
        return (c.kind != PK_NONE) && (c.black == side);
    endfunction

    function automatic logic is_foe(cell_t c, logic side);
        return (c.kind != PK_NONE) && (c.black != side);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int isign(int v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    function automatic logic on_board(int r, int f);
        return (r >= 0) && (r < BOARD_DIM) && (f >= 0) && (f < BOARD_DIM);
    endfunction

    function automatic logic [SQ_W-1:0] sq_of(int r, int f);
        return SQ_W'(r * BOARD_DIM + f);
    endfunction

    // unit steps: 0..3 orthogonal, 4..7 diagonal
    function automatic int ray_dr(int d);
        case (d)
            0: return 1;   1: return -1;  2: return 0;   3: return 0;
            4: return 1;   5: return 1;   6: return -1;  default: return -1;
        endcase
    endfunction

    function automatic int ray_df(int d);
        case (d)
            0: return 0;   1: return 0;   2: return 1;   3: return -1;
            4: return 1;   5: return -1;  6: return 1;   default: return -1;
        endcase
    endfunction

    function automatic int jump_dr(int j);
        case (j)
            0: return 1;  1: return 2;  2: return -1; 3: return -2;
            4: return 1;  5: return 2;  6: return -1; default: return -2;
        endcase
    endfunction

    function automatic int jump_df(int j);
        case (j)
            0: return 2;  1: return 1;  2: return 2;  3: return 1;
            4: return -2; 5: return -1; 6: return -2; default: return -1;
        endcase
    endfunction

    // squares strictly between (fr,ff) and (fr+dr,ff+df) are empty
    function automatic logic path_clear(board_t b, int fr, int ff, int dr, int df);
        int   steps;
        logic clear;
        steps = (iabs(dr) > iabs(df)) ? iabs(dr) : iabs(df);
        clear = 1'b1;
        for (int k = 1; k < BOARD_DIM; k++) begin
            if (k < steps) begin
                if (b[sq_of(fr + k * isign(dr), ff + k * isign(df))].kind != PK_NONE)
                    clear = 1'b0;
            end
        end
        return clear;
    endfunction

    // aggressor view: can the piece on src move to dst
    function automatic logic reaches(board_t b, logic side, logic [SQ_W-1:0] src,
                                     logic [SQ_W-1:0] dst);
        cell_t p, q;
        int    fr, ff, dr, df, ar, af, fwd, home;
        logic  ok;
        p    = b[src];
        q    = b[dst];
        fr   = int'(src) / BOARD_DIM;
        ff   = int'(src) % BOARD_DIM;
        dr   = int'(dst) / BOARD_DIM - fr;
        df   = int'(dst) % BOARD_DIM - ff;
        ar   = iabs(dr);
        af   = iabs(df);
        fwd  = side ? -1 : 1;
        home = side ? BOARD_DIM - 2 : 1;
        ok   = 1'b0;
        if (is_own(p, side) && !is_own(q, side) && (src != dst)) begin
            case (p.kind)
                PK_PAWN: begin
                    if (df == 0 && q.kind == PK_NONE) begin
                        if (dr == fwd)
                            ok = 1'b1;
                        else if (dr == 2 * fwd && fr == home &&
                                 b[sq_of(fr + fwd, ff)].kind == PK_NONE)
                            ok = 1'b1;
                    end else if (af == 1 && dr == fwd && is_foe(q, side)) begin
                        ok = 1'b1;
                    end
                end
                PK_KNIGHT: ok = (ar == 1 && af == 2) || (ar == 2 && af == 1);
                PK_KING:   ok = (ar <= 1) && (af <= 1);
                PK_BISHOP: ok = (ar == af) && path_clear(b, fr, ff, dr, df);
                PK_ROOK:   ok = (ar == 0 || af == 0) && path_clear(b, fr, ff, dr, df);
                PK_QUEEN:  ok = (ar == af || ar == 0 || af == 0) &&
                                path_clear(b, fr, ff, dr, df);
                default:   ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    // victim view: does any piece of side land on t (scan outward from t)
    function automatic logic victim_hit(board_t b, logic side, logic [SQ_W-1:0] t);
        cell_t q, c;
        int    tr, tf, r, f, fwd, home;
        logic  hit, blocked;
        q    = b[t];
        tr   = int'(t) / BOARD_DIM;
        tf   = int'(t) % BOARD_DIM;
        fwd  = side ? -1 : 1;
        home = side ? BOARD_DIM - 2 : 1;
        hit  = 1'b0;
        for (int d = 0; d < 8; d++) begin
            blocked = 1'b0;
            for (int k = 1; k < BOARD_DIM; k++) begin
                r = tr + k * ray_dr(d);
                f = tf + k * ray_df(d);
                if (!blocked && on_board(r, f)) begin
                    c = b[sq_of(r, f)];
                    if (c.kind != PK_NONE) begin
                        blocked = 1'b1;
                        if (is_own(c, side)) begin
                            if (k == 1 && c.kind == PK_KING) hit = 1'b1;
                            if (c.kind == PK_QUEEN ||
                                c.kind == ((d < 4) ? PK_ROOK : PK_BISHOP)) hit = 1'b1;
                        end
                    end
                end
            end
        end
        for (int j = 0; j < 8; j++) begin
            r = tr + jump_dr(j);
            f = tf + jump_df(j);
            if (on_board(r, f)) begin
                c = b[sq_of(r, f)];
                if (is_own(c, side) && c.kind == PK_KNIGHT) hit = 1'b1;
            end
        end
        r = tr - fwd;
        if (q.kind == PK_NONE && on_board(r, tf)) begin
            c = b[sq_of(r, tf)];
            if (is_own(c, side) && c.kind == PK_PAWN) begin
                hit = 1'b1;
            end else if (c.kind == PK_NONE && (r - fwd) == home && on_board(r - fwd, tf)) begin
                c = b[sq_of(r - fwd, tf)];
                if (is_own(c, side) && c.kind == PK_PAWN) hit = 1'b1;
            end
        end
        if (is_foe(q, side)) begin
            for (int s = -1; s <= 1; s += 2) begin
                if (on_board(r, tf + s)) begin
                    c = b[sq_of(r, tf + s)];
                    if (is_own(c, side) && c.kind == PK_PAWN) hit = 1'b1;
                end
            end
        end
        if (is_own(q, side)) hit = 1'b0;
        return hit;
    endfunction

endpackage

// File: rtl/mvg_victim_cell.sv
module mvg_victim_cell
    import mvg_pkg::*;
#(
    parameter int SQ = 0
) (
    input  board_t                board,
    input  logic                  side,
    input  logic                  spent,
    input  logic                  killer_ok,
    input  logic [SQ_W-1:0]       killer_to,
    output logic                  cand,
    output logic [SCORE_W-1:0]    score
);
    localparam logic [SQ_W-1:0] MY_SQ = SQ_W'(SQ);

    cell_t here;
    assign here = board[MY_SQ];

    assign cand = !spent && victim_hit(board, side, MY_SQ);

    always_comb begin
        if (is_foe(here, side))
            score = SCORE_W'(2 + int'(here.kind));
        else if (killer_ok && killer_to == MY_SQ)
            score = SCORE_W'(1);
        else
            score = '0;
    end
endmodule

// File: rtl/mvg_aggressor_cell.sv
module mvg_aggressor_cell
    import mvg_pkg::*;
#(
    parameter int SQ = 0
) (
    input  board_t              board,
    input  logic                side,
    input  logic [SQ_W-1:0]     target,
    output logic                origin,
    output logic [RANK_W-1:0]   cheapness
);
    localparam logic [SQ_W-1:0] MY_SQ = SQ_W'(SQ);

    assign origin    = reaches(board, side, MY_SQ, target);
    // cheaper attacker -> larger key, so the max-tree prefers it
    assign cheapness = RANK_W'(7 - int'(board[MY_SQ].kind));
endmodule

// File: rtl/mvg_arbiter.sv
module mvg_arbiter #(
    parameter int N_LEAF = 64,
    parameter int KEY_W  = 4,
    localparam int IDX_W = $clog2(N_LEAF)
) (
    input  logic [N_LEAF-1:0]            req,
    input  logic [N_LEAF-1:0][KEY_W-1:0] key,
    output logic                         any,
    output logic [IDX_W-1:0]             idx
);
    localparam int N_NODE = 2 * N_LEAF - 1;

    logic             nv [N_NODE];
    logic [KEY_W-1:0] nk [N_NODE];
    logic [IDX_W-1:0] ni [N_NODE];

    for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
        assign nv[N_LEAF-1+g] = req[g];
        assign nk[N_LEAF-1+g] = key[g];
        assign ni[N_LEAF-1+g] = IDX_W'(g);
    end

    // left subtree holds lower indices; it wins ties
    for (genvar n = 0; n < N_LEAF - 1; n++) begin : g_node
        logic take_right;
        assign take_right = nv[2*n+2] && (!nv[2*n+1] || nk[2*n+2] > nk[2*n+1]);
        assign nv[n] = nv[2*n+1] || nv[2*n+2];
        assign nk[n] = take_right ? nk[2*n+2] : nk[2*n+1];
        assign ni[n] = take_right ? ni[2*n+2] : ni[2*n+1];
    end

    assign any = nv[0];
    assign idx = ni[0];

    always_comb begin
        if (!$isunknown(req) && any) begin
            p_pick_requests_r7: assert (req[idx]);
            for (int g = 0; g < N_LEAF; g++) begin
                p_pick_max_key_r4: assert (!(req[g] && key[g] > key[idx]));
                p_tie_lowest_r7: assert (!(req[g] && key[g] == key[idx] && g < int'(idx)));
            end
        end
    end
endmodule

// File: rtl/chess_mvgen.sv
module chess_mvgen
    import mvg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [N_SQ*CELL_W-1:0]   board_in,
    input  logic                     side_in,
    input  logic [SQ_W-1:0]          killer_from,
    input  logic [SQ_W-1:0]          killer_to,
    input  logic                     next,
    output logic                     mv_valid,
    output logic [SQ_W-1:0]          mv_from,
    output logic [SQ_W-1:0]          mv_to,
    output logic                     done
);
    board_t          board_q;
    logic            side_q;
    logic [SQ_W-1:0] kfrom_q, kto_q;
    logic [N_SQ-1:0] examined_q;
    logic [N_SQ-1:0] emitted_q;

    logic                          killer_ok;
    logic [N_SQ-1:0]               tgt_cand;
    logic [N_SQ-1:0][SCORE_W-1:0]  tgt_score;
    logic                          tgt_any;
    logic [SQ_W-1:0]               tgt_idx;
    logic [N_SQ-1:0]               org_flag;
    logic [N_SQ-1:0]               org_live;
    logic [N_SQ-1:0][RANK_W-1:0]   org_key;
    logic                          org_any;
    logic [SQ_W-1:0]               org_idx;
    logic [N_SQ-1:0]               org_rest;

    // killer only earns its bonus when it is itself a quiet pseudo-legal move
    assign killer_ok = reaches(board_q, side_q, kfrom_q, kto_q) &&
                       board_q[kto_q].kind == PK_NONE;

    for (genvar s = 0; s < N_SQ; s++) begin : g_sq
        mvg_victim_cell #(.SQ(s)) u_vic (
            .board     (board_q),
            .side      (side_q),
            .spent     (examined_q[s]),
            .killer_ok (killer_ok),
            .killer_to (kto_q),
            .cand      (tgt_cand[s]),
            .score     (tgt_score[s])
        );
        mvg_aggressor_cell #(.SQ(s)) u_agg (
            .board     (board_q),
            .side      (side_q),
            .target    (tgt_idx),
            .origin    (org_flag[s]),
            .cheapness (org_key[s])
        );
    end

    mvg_arbiter #(.N_LEAF(N_SQ), .KEY_W(SCORE_W)) u_tgt_arb (
        .req (tgt_cand),
        .key (tgt_score),
        .any (tgt_any),
        .idx (tgt_idx)
    );

    assign org_live = org_flag & ~emitted_q;

    mvg_arbiter #(.N_LEAF(N_SQ), .KEY_W(RANK_W)) u_org_arb (
        .req (org_live),
        .key (org_key),
        .any (org_any),
        .idx (org_idx)
    );

    assign org_rest = org_live & ~(N_SQ'(1) << org_idx);

    assign mv_valid = tgt_any && org_any;
    assign mv_from  = org_idx;
    assign mv_to    = tgt_idx;
    assign done     = !tgt_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            board_q    <= '0;
            side_q     <= 1'b0;
            kfrom_q    <= '0;
            kto_q      <= '0;
            examined_q <= '0;
            emitted_q  <= '0;
        end else if (load) begin
            board_q    <= board_t'(board_in);
            side_q     <= side_in;
            kfrom_q    <= killer_from;
            kto_q      <= killer_to;
            examined_q <= '0;
            emitted_q  <= '0;
        end else if (next && mv_valid) begin
            if (org_rest == '0) begin
                examined_q[tgt_idx] <= 1'b1;
                emitted_q           <= '0;
            end else begin
                emitted_q[org_idx]  <= 1'b1;
            end
        end
    end

    // every victim flag is backed by at least one aggressor
    p_victim_has_origin_r2: assert property (@(posedge clk) disable iff (rst)
        tgt_any |-> org_any);
    p_origin_is_own_r2: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (board_q[mv_from].kind != PK_NONE && board_q[mv_from].black == side_q));
    p_target_not_own_r2: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> !is_own(board_q[mv_to], side_q));
    p_valid_vs_done_r8: assert property (@(posedge clk) disable iff (rst)
        mv_valid != done);
    p_target_unspent_r3: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> !examined_q[mv_to]);
    p_examined_grows_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((examined_q & $past(examined_q)) == $past(examined_q)));
    p_load_clears_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (examined_q == '0 && emitted_q == '0));
    p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);
endmodule

// File: tb/chess_mvgen_test.sv
module chess_mvgen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [255:0] board_in = '0;
    logic         side_in = 1'b0;
    logic [5:0]   killer_from = '0;
    logic [5:0]   killer_to = '0;
    logic         next = 1'b0;
    logic         mv_valid;
    logic [5:0]   mv_from;
    logic [5:0]   mv_to;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chess_mvgen uut (
        .clk(clk), .rst(rst), .load(load), .board_in(board_in), .side_in(side_in),
        .killer_from(killer_from), .killer_to(killer_to), .next(next),
        .mv_valid(mv_valid), .mv_from(mv_from), .mv_to(mv_to), .done(done)
    );

    logic [3:0]  bd [64];
    logic        bside;
    int          kf, kt;
    logic [63:0] exp_to [64];
    logic [63:0] seen [64];
    int          first_f, first_t;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic own(int s);
        return bd[s][2:0] != 3'd0 && bd[s][3] == bside;
    endfunction
    function automatic logic foe(int s);
        return bd[s][2:0] != 3'd0 && bd[s][3] != bside;
    endfunction
    function automatic logic inb(int r, int c);
        return r >= 0 && r < 8 && c >= 0 && c < 8;
    endfunction

    // piece-centric reference list of pseudo-legal moves
    function automatic void build_ref();
        int kr[8] = '{1, 2, -1, -2, 1, 2, -1, -2};
        int kc[8] = '{2, 1, 2, 1, -2, -1, -2, -1};
        int gr[8] = '{1, 1, 1, 0, 0, -1, -1, -1};
        int gc[8] = '{-1, 0, 1, -1, 1, -1, 0, 1};
        int sr[8] = '{1, -1, 0, 0, 1, 1, -1, -1};
        int sc[8] = '{0, 0, 1, -1, 1, -1, 1, -1};
        for (int f = 0; f < 64; f++) exp_to[f] = '0;
        for (int f = 0; f < 64; f++) begin
            int r = f / 8;
            int c = f % 8;
            int kind = int'(bd[f][2:0]);
            if (!own(f)) continue;
            if (kind == 1) begin
                int fw = bside ? -1 : 1;
                if (inb(r + fw, c) && bd[(r + fw) * 8 + c][2:0] == 0) begin
                    exp_to[f][(r + fw) * 8 + c] = 1'b1;
                    if (r == (bside ? 6 : 1) && bd[(r + 2 * fw) * 8 + c][2:0] == 0)
                        exp_to[f][(r + 2 * fw) * 8 + c] = 1'b1;
                end
                for (int dc = -1; dc <= 1; dc += 2)
                    if (inb(r + fw, c + dc) && foe((r + fw) * 8 + c + dc))
                        exp_to[f][(r + fw) * 8 + c + dc] = 1'b1;
            end else if (kind == 2 || kind == 6) begin
                for (int j = 0; j < 8; j++) begin
                    int rr = r + ((kind == 2) ? kr[j] : gr[j]);
                    int cc = c + ((kind == 2) ? kc[j] : gc[j]);
                    if (inb(rr, cc) && !own(rr * 8 + cc)) exp_to[f][rr * 8 + cc] = 1'b1;
                end
            end else if (kind >= 3 && kind <= 5) begin
                for (int d = 0; d < 8; d++) begin
                    int rr = r;
                    int cc = c;
                    if (kind == 3 && d < 4) continue;
                    if (kind == 4 && d >= 4) continue;
                    for (int k = 0; k < 7; k++) begin
                        rr += sr[d];
                        cc += sc[d];
                        if (!inb(rr, cc)) break;
                        if (!own(rr * 8 + cc)) exp_to[f][rr * 8 + cc] = 1'b1;
                        if (bd[rr * 8 + cc][2:0] != 0) break;
                    end
                end
            end
        end
    endfunction

    function automatic int tscore(int t);
        if (foe(t)) return 2 + int'(bd[t][2:0]);
        if (t == kt && bd[t][2:0] == 0 && exp_to[kf][t]) return 1;
        return 0;
    endfunction

    task automatic run_pos(input string name, input logic cmp_first);
        int total = 0;
        int n = 0;
        int pf = -1, pt = -1, psc = 0, pav = 0;
        build_ref();
        for (int f = 0; f < 64; f++) begin
            total += $countones(exp_to[f]);
            seen[f] = '0;
        end
        @(negedge clk);
        for (int s = 0; s < 64; s++) board_in[4*s +: 4] = bd[s];
        side_in = bside;
        killer_from = 6'(kf);
        killer_to = 6'(kt);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        while (!done && n < 400) begin
            int f = int'(mv_from);
            int t = int'(mv_to);
            int sc = tscore(t);
            int av = int'(bd[f][2:0]);
            chk(mv_valid, {"R8 valid while not done ", name}, int'(mv_valid), 1);
            chk(exp_to[f][t] && !seen[f][t], {"R2 R10 R3 move legal and new ", name},
                f * 64 + t, f * 64 + t);
            if (n == 0 && cmp_first)
                chk(f == first_f && t == first_t, {"R9 reload restarts ", name},
                    f * 64 + t, first_f * 64 + first_t);
            if (n == 0) begin first_f = f; first_t = t; end
            if (n > 0) begin
                if (t == pt)
                    chk(av > pav || (av == pav && f > pf), {"R6 attacker order ", name},
                        av * 64 + f, pav * 64 + pf);
                else
                    chk(sc < psc || (sc == psc && t > pt), {"R4 R5 R7 target order ", name},
                        sc * 64 + t, psc * 64 + pt);
            end
            seen[f][t] = 1'b1;
            pf = f; pt = t; psc = sc; pav = av;
            n++;
            next = 1'b1;
            @(negedge clk);
            next = 1'b0;
        end
        chk(n == total, {"R3 move count ", name}, n, total);
        chk(done && !mv_valid, {"R8 done at end ", name}, int'(done), 1);
        next = 1'b1;
        @(negedge clk);
        @(negedge clk);
        next = 1'b0;
        chk(done && !mv_valid, {"R8 next ignored when done ", name}, int'(mv_valid), 0);
    endtask

    function automatic void clear_board();
        for (int s = 0; s < 64; s++) bd[s] = 4'h0;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b1 && mv_valid == 1'b0, "R1 reset state", int'(done), 1);

        // queen on e5 hit by pawn, knight and rook; killer knight f3-d2
        clear_board();
        bd[36] = 4'hD; bd[27] = 4'h1; bd[21] = 4'h2; bd[4] = 4'h4;
        bd[7] = 4'h6;  bd[63] = 4'hE; bd[10] = 4'h1;
        bside = 1'b0; kf = 21; kt = 11;
        run_pos("captures_killer", 1'b0);
        run_pos("captures_killer_reload", 1'b1);

        // black to move: blocked double push, pawn captures, king quiet killer
        clear_board();
        bd[60] = 4'hE; bd[0] = 4'h6; bd[51] = 4'h9; bd[52] = 4'h9;
        bd[35] = 4'h2; bd[45] = 4'h3; bd[43] = 4'h0; bd[53] = 4'h9; bd[37] = 4'h4;
        bside = 1'b1; kf = 60; kt = 59;
        run_pos("black_pawns", 1'b0);

        // sliders blocked by own and enemy pieces, equal-score targets
        clear_board();
        bd[2] = 4'h3; bd[11] = 4'h1; bd[27] = 4'h5; bd[43] = 4'h9; bd[30] = 4'h9;
        bd[24] = 4'h4; bd[6] = 4'h6; bd[62] = 4'hE; bd[14] = 4'h1;
        bside = 1'b0; kf = 2; kt = 9;
        run_pos("sliders", 1'b0);

        for (int p = 0; p < 20; p++) begin
            clear_board();
            for (int s = 0; s < 64; s++)
                if ($urandom_range(99) < 18)
                    bd[s] = {1'($urandom_range(1)), 3'($urandom_range(6, 1))};
            bside = 1'($urandom_range(1));
            kf = $urandom_range(63);
            kt = $urandom_range(63);
            run_pos($sformatf("random_%0d", p), 1'b0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule